// File: doc/BRIEF.md
# Set-Clear-Toggle Register Bank

This block is a bank of 32-bit control registers on a simple single-cycle register bus. Each register sits in its own 16-byte address slot. The slot holds four aliases, and bits [3:2] of the address choose what a write does to the stored word. The word can be replaced, given extra bits with OR, have bits removed, or have bits inverted. Software can therefore change a few control bits in one bus write, with no read-modify-write sequence and no race against other writers of the same word.

A read through any alias of a slot returns the stored word unchanged, one cycle after the request. Only aligned 32-bit accesses are accepted. An access whose two lowest address bits are not zero does nothing. An access to a slot past the last register also does nothing. Every register value is driven straight out on a wide output so that neighbouring logic can use the control bits. A synchronous reset clears the whole bank.

Top module: `scb_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to zero, and `bus_rdata` is zero in the cycle after that edge.
- R2: A write with address bits [3:0] = 0x0 replaces the addressed register with `bus_wdata`.
- R3: A write with address bits [3:0] = 0x4 ORs `bus_wdata` into the addressed register.
- R4: A write with address bits [3:0] = 0x8 clears each register bit whose `bus_wdata` bit is one, and leaves the other bits as they are.
- R5: A write with address bits [3:0] = 0xC XORs `bus_wdata` into the addressed register.
- R6: The register index is address bits [ADDR_W-1:4], so registers are 16 bytes apart. Register i is presented on `reg_q[i*32 +: 32]`.
- R7: A read (`bus_re` high) from any of the four aliases of an in-range, aligned slot puts the stored word on `bus_rdata` in the next cycle and leaves the register unchanged. In a cycle that follows no accepted read, `bus_rdata` is zero.
- R8: A write takes effect at the rising edge where `bus_we` is sampled high, and the new value is on `reg_q` right after that edge.
- R9: If the slot index is NUM_REGS or more, a write changes no register and a read returns zero.
- R10: If address bits [1:0] are not zero, a write changes no register and a read returns zero.
- R11: When a read and a write target the same slot in the same cycle, the read returns the value from before the write.
- R12: A register that is not the target of an accepted write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address: slot in [ADDR_W-1:4], operation in [3:2], alignment in [1:0] |
| bus_we | input | 1 | Write request for this cycle |
| bus_wdata | input | DATA_W | Write operand |
| bus_re | input | 1 | Read request for this cycle |
| bus_rdata | output | DATA_W | Read result, valid the cycle after `bus_re` |
| reg_q | output | NUM_REGS*DATA_W | All stored words, register i in bits [i*DATA_W +: DATA_W] |

## Verification
The assertions assume that the bus inputs are known (not X) at every rising edge after reset, and that `rst` is held for at least one edge before the first access. The bench drives every input just after a falling edge and drops both requests after each access. Its reference model keeps a plain array of words. After every edge it compares the whole `reg_q` vector and `bus_rdata` against that array. The stimulus covers the misaligned and out-of-range addresses on purpose. The long mixed phase uses only aligned, in-range addresses, so that the model is exercised on real writes.

// File: rtl/scb_pkg.sv
package scb_pkg;

    // Operation chosen by address bits [3:2] of a write
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } scb_op_e;

    localparam int SLOT_LSB = 4;
    localparam int OP_LSB   = 2;

endpackage

// File: rtl/scb_decode.sv
module scb_decode
    import scb_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [NUM_REGS-1:0] wr_sel,
    output scb_op_e             op,
    output logic                rd_ok,
    output logic [IDX_W-1:0]    rd_idx
);

    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              in_range;

    assign slot     = bus_addr[ADDR_W-1:SLOT_LSB];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign in_range = (32'(slot) < 32'(NUM_REGS));
    assign rd_ok    = bus_re && aligned && in_range;
    assign rd_idx   = slot[IDX_W-1:0];

    always_comb begin
        unique case (bus_addr[OP_LSB+1:OP_LSB])
            2'd0:    op = OP_WRITE;
            2'd1:    op = OP_SET;
            2'd2:    op = OP_CLEAR;
            default: op = OP_TOGGLE;
        endcase
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = bus_we && aligned && (32'(slot) == i);
    end

    // At most one register is written per access (R6)
    p_one_target_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    // A misaligned access reaches no register (R10)
    p_misaligned_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (wr_sel == '0 && !rd_ok));

    // A slot past the bank reaches no register (R9)
    p_out_of_range_r9: assert property (@(posedge clk) disable iff (rst)
        (32'(slot) >= 32'(NUM_REGS)) |-> (wr_sel == '0 && !rd_ok));

endmodule

// File: rtl/scb_cell.sv
module scb_cell
    import scb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  scb_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] next_q;

    always_comb begin
        next_q = q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE:  next_q = wdata;
                OP_SET:    next_q = q | wdata;
                OP_CLEAR:  next_q = q & ~wdata;
                OP_TOGGLE: next_q = q ^ wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= next_q;
        end
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_WRITE) |=> (q == $past(wdata)));

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_CLEAR) |=> ((q & $past(wdata)) == '0));

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_TOGGLE) |=> ((q ^ $past(q)) == $past(wdata)));

endmodule

// File: rtl/scb_readmux.sv
module scb_readmux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_ok,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [DATA_W-1:0]          rdata
);

    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        assign words[i] = regs_flat[i*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_ok) begin
            rdata <= words[rd_idx];
        end else begin
            rdata <= '0;
        end
    end

    // No accepted read means a zero result next cycle (R7)
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |=> (rdata == '0));

endmodule

// File: rtl/scb_bank.sv
module scb_bank
    import scb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_re,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] reg_q
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0] wr_sel;
    scb_op_e             op;
    logic                rd_ok;
    logic [IDX_W-1:0]    rd_idx;

    scb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .wr_sel   (wr_sel),
        .op       (op),
        .rd_ok    (rd_ok),
        .rd_idx   (rd_idx)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        scb_cell #(
            .DATA_W (DATA_W)
        ) u_cell (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel[i]),
            .op    (op),
            .wdata (bus_wdata),
            .q     (reg_q[i*DATA_W +: DATA_W])
        );
    end

    scb_readmux #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_readmux (
        .clk       (clk),
        .rst       (rst),
        .rd_ok     (rd_ok),
        .rd_idx    (rd_idx),
        .regs_flat (reg_q),
        .rdata     (bus_rdata)
    );

    // Reset leaves the whole bank at zero (R1)
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_q == '0 && bus_rdata == '0));

endmodule

// File: tb/scb_bank_bench.sv
module scb_bank_bench;

    localparam int NREG = 8;
    localparam int AW   = 12;
    localparam int DW   = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic              bus_re = 1'b0;
    logic [DW-1:0]     bus_rdata;
    logic [NREG*DW-1:0] reg_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [NREG];

    always #4 clk = ~clk;

    scb_bank #(.NUM_REGS(NREG), .ADDR_W(AW), .DATA_W(DW)) u_scb_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .reg_q     (reg_q)
    );

    task automatic check_word(input string tag, input string what,
                              input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++) begin
            check_word(tag, $sformatf("reg_q word %0d", i), reg_q[i*DW +: DW], model[i]);
        end
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        bus_we = 1'b0;
        bus_re = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(negedge clk);
        check_bank(tag);
        check_word(tag, "bus_rdata", bus_rdata, '0);
        rst = 1'b0;
    endtask

    task automatic step(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                        input logic re, input string tag);
        logic [DW-1:0] exp_rd;
        int  slot;
        bit  ok;
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        bus_re    = re;
        @(posedge clk);
        slot   = int'(a[AW-1:4]);
        ok     = (a[1:0] == 2'b00) && (slot < NREG);
        exp_rd = '0;
        if (re && ok) exp_rd = model[slot];
        if (we && ok) begin
            case (a[3:0])
                4'h0:    model[slot] = wd;
                4'h4:    model[slot] = model[slot] | wd;
                4'h8:    model[slot] = model[slot] & ~wd;
                default: model[slot] = model[slot] ^ wd;
            endcase
        end
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
        check_bank(tag);
        check_word(tag, "bus_rdata", bus_rdata, exp_rd);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(negedge clk);
        do_reset("R1");

        // plain write, visible right after the edge, read through all aliases
        step(12'h000, 1'b1, 32'hA5A5_0F0F, 1'b0, "R2 R8");
        step(12'h000, 1'b0, 32'h0, 1'b1, "R7 alias 0x0");
        step(12'h004, 1'b0, 32'h0, 1'b1, "R7 alias 0x4");
        step(12'h008, 1'b0, 32'h0, 1'b1, "R7 alias 0x8");
        step(12'h00C, 1'b0, 32'h0, 1'b1, "R7 alias 0xC");
        step(12'h000, 1'b0, 32'h0, 1'b0, "R7 idle");

        // set and clear on slot 1
        step(12'h010, 1'b1, 32'h0000_00F0, 1'b0, "R2");
        step(12'h014, 1'b1, 32'h0F00_000F, 1'b1, "R3");
        step(12'h018, 1'b1, 32'h0000_00FF, 1'b1, "R4");
        step(12'h010, 1'b0, 32'h0, 1'b1, "R4 readback");

        // toggle on slot 2 twice
        step(12'h02C, 1'b1, 32'hFFFF_0000, 1'b0, "R5");
        step(12'h02C, 1'b1, 32'hFF00_FF00, 1'b1, "R5");

        // slot spacing and output position
        step(12'h070, 1'b1, 32'h7777_0007, 1'b0, "R6 last slot");
        step(12'h034, 1'b1, 32'h0000_3000, 1'b0, "R6 slot 3");
        step(12'h07C, 1'b0, 32'h0, 1'b1, "R6 read last");

        // out of range slots
        step(12'h080, 1'b1, 32'hDEAD_BEEF, 1'b0, "R9 write");
        step(12'hFF4, 1'b1, 32'hFFFF_FFFF, 1'b0, "R9 write high");
        step(12'h080, 1'b0, 32'h0, 1'b1, "R9 read");

        // misaligned addresses
        step(12'h001, 1'b1, 32'h1234_5678, 1'b0, "R10 write 0x1");
        step(12'h016, 1'b1, 32'hFFFF_FFFF, 1'b0, "R10 write 0x16");
        step(12'h02B, 1'b1, 32'hFFFF_FFFF, 1'b0, "R10 write 0x2B");
        step(12'h002, 1'b0, 32'h0, 1'b1, "R10 read");

        // read and write to one slot in one cycle
        step(12'h000, 1'b1, 32'h0BAD_F00D, 1'b1, "R11 write");
        step(12'h00C, 1'b1, 32'h0000_FFFF, 1'b1, "R11 toggle");
        step(12'h000, 1'b0, 32'h0, 1'b1, "R11 after");

        // long mixed run on aligned in-range addresses
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = {AW{1'b0}};
            a[6:4] = 3'($urandom_range(0, NREG - 1));
            a[3:2] = 2'($urandom_range(0, 3));
            step(a, 1'($urandom_range(0, 1)), $urandom(), 1'($urandom_range(0, 1)), "R12 mixed");
        end

        // reset again with data present
        do_reset("R1 second");
        step(12'h070, 1'b0, 32'h0, 1'b1, "R1 read after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule